// File: doc/BRIEF.md
# SPI Master Bit-Rate Generator with Dual-View Prescale Register

This block produces the serial clock for one SPI data format when the controller acts as bus master. An 11-bit prescale value divides the peripheral clock, so the serial clock runs at the peripheral rate divided by (prescale + 1), anywhere from 1 to 2048. Software can write the prescale value through two register views. The narrow view is an 8-bit field in bits 15:8 of a format word. The wide view is an 11-bit field in bits 10:0 of a separate word. Both views reach one shared storage register.

A write through the narrow view loads the low 8 bits and clears the top three bits, so a legacy driver can never leave a stale high part behind. A read through either view shows the value from the most recent write, whichever view made it. The divider takes a new value only at the end of a serial-clock period, so a write never cuts a period short.

There is no data stream here. The register port is a plain single-cycle write strobe with a combinational read mux, and the enable is a level. A slave-mode user simply holds the enable low, and the prescaler then has no effect on the output.

Top module: `spi_baud_gen`

## Requirements
- R1: After reset the stored prescale is 0, both read views return 0x0000, and `sclk` is low.
- R2: A write with `wr_view`=1 (extended view) stores `wr_data[10:0]`; reading with `rd_view`=1 returns the stored value in bits 10:0 with bits 15:11 zero.
- R3: A write with `wr_view`=0 (format view) stores `wr_data[15:8]` into prescale bits 7:0 and forces prescale bits 10:8 to zero.
- R4: Reading with `rd_view`=0 returns prescale bits 7:0 in bits 15:8, with all other bits zero. Both views reflect the latest write made through either view.
- R5: While enabled with prescale P>0, `sclk` is periodic with period P+1 clock cycles. It is high for the first ceil((P+1)/2) cycles of each period and low for the rest, so the high phase is one cycle longer when P+1 is odd.
- R6: While enabled with prescale 0, `sclk` equals `clk`.
- R7: A prescale value written while running takes effect only at the next period boundary. The current period completes at the old length.
- R8: When `master_en` goes low, the current period completes and `sclk` then stays low. With `master_en` low from reset, `sclk` stays low.
- R9: With `wr_en` low, the values on `wr_view` and `wr_data` do not change the stored prescale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Master-mode clock enable (level) |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_view | input | 1 | Write target: 0 = format view, 1 = extended view |
| wr_data | input | 16 | Write data word |
| rd_view | input | 1 | Read source: 0 = format view, 1 = extended view |
| rd_data | output | 16 | Read data for the selected view (combinational) |
| sclk | output | 1 | Serial clock output, idle low |

## Verification
The divider is run with prescale 0 (clock pass-through), with even and odd ratios, and with the full 11-bit maximum. These separate the pass-through path from the counter path and expose an asymmetric duty cycle on odd ratios. New values are written in the middle of a period through both views, so a design that reloads immediately is caught by a shortened period. A legacy write that follows a large extended write tells correct upper-bit clearing apart from plain overlay. Dropping the enable mid-period, and presenting write data with the strobe low, check the period-completion and no-effect rules at `sclk` and `rd_data`.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;
  localparam int PS_W    = 11;  // full prescale width
  localparam int LEG_W   = 8;   // narrow view width
  localparam int LEG_LSB = 8;   // narrow field position in the format word
  localparam int REG_W   = 16;  // register word width

  typedef enum logic {
    VIEW_FMT = 1'b0,
    VIEW_EXT = 1'b1
  } view_e;
endpackage

// File: rtl/prescale_store.sv
module prescale_store
  import spi_baud_pkg::*;
#(
  parameter int P_W   = PS_W,
  parameter int L_W   = LEG_W,
  parameter int L_LSB = LEG_LSB,
  parameter int R_W   = REG_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           wr_view,
  input  logic [R_W-1:0] wr_data,
  input  logic           rd_view,
  output logic [R_W-1:0] rd_data,
  output logic [P_W-1:0] value_o
);
  localparam int HI_W = P_W - L_W;

  logic [P_W-1:0] store_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
    end else if (wr_en) begin
      if (view_e'(wr_view) == VIEW_EXT) store_q <= wr_data[P_W-1:0];
      else                              store_q <= {{HI_W{1'b0}}, wr_data[L_LSB+L_W-1:L_LSB]};
    end
  end

  always_comb begin
    rd_data = '0;
    if (view_e'(rd_view) == VIEW_EXT) rd_data[P_W-1:0] = store_q;
    else                              rd_data[L_LSB+L_W-1:L_LSB] = store_q[L_W-1:0];
  end

  assign value_o = store_q;

  // R3
  legacy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_view) |=> (store_q[P_W-1:L_W] == '0));

  // R2
  ext_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_view) |=> (store_q == $past(wr_data[P_W-1:0])));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(store_q));
endmodule

// File: rtl/baud_divider.sv
module baud_divider
  import spi_baud_pkg::*;
#(
  parameter int P_W = PS_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [P_W-1:0] ps_i,
  output logic           sclk_o
);
  logic           run_q, run_n;
  logic [P_W-1:0] div_q, div_n;
  logic [P_W-1:0] cnt_q, cnt_n;
  logic           sclk_q;

  always_comb begin
    run_n = run_q;
    div_n = div_q;
    cnt_n = cnt_q;
    if (!run_q) begin
      if (en) begin
        run_n = 1'b1;
        div_n = ps_i;
        cnt_n = '0;
      end
    end else if (cnt_q == div_q) begin
      cnt_n = '0;
      if (en) div_n = ps_i;
      else    run_n = 1'b0;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      div_q  <= '0;
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      run_q  <= run_n;
      div_q  <= div_n;
      cnt_q  <= cnt_n;
      sclk_q <= run_n && (cnt_n <= (div_n >> 1));
    end
  end

  assign sclk_o = run_q && ((div_q == '0) ? clk : sclk_q);

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q <= div_q));

  // R7
  div_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q != div_q) |=> $stable(div_q));

  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !en) |=> (!run_q && !sclk_q));
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
  import spi_baud_pkg::*;
#(
  parameter int P_W   = PS_W,
  parameter int L_W   = LEG_W,
  parameter int L_LSB = LEG_LSB,
  parameter int R_W   = REG_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           master_en,
  input  logic           wr_en,
  input  logic           wr_view,
  input  logic [R_W-1:0] wr_data,
  input  logic           rd_view,
  output logic [R_W-1:0] rd_data,
  output logic           sclk
);
  logic [P_W-1:0] ps_val;

  prescale_store #(.P_W(P_W), .L_W(L_W), .L_LSB(L_LSB), .R_W(R_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_view (wr_view),
    .wr_data (wr_data),
    .rd_view (rd_view),
    .rd_data (rd_data),
    .value_o (ps_val)
  );

  baud_divider #(.P_W(P_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (master_en),
    .ps_i   (ps_val),
    .sclk_o (sclk)
  );
endmodule

// File: tb/spi_baud_gen_tb.sv
`timescale 1ns/1ps
module spi_baud_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        master_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_view = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_view = 1'b0;
  logic [15:0] rd_data;
  logic        sclk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  int m_store = 0;
  int m_run = 0;
  int m_pos = 0;
  int m_div = 0;

  always #2 clk = ~clk;  // 250 MHz

  spi_baud_gen dut_i (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .wr_en(wr_en),
    .wr_view(wr_view), .wr_data(wr_data), .rd_view(rd_view),
    .rd_data(rd_data), .sclk(sclk)
  );

  // model: position inside the current serial period, new length adopted at boundary
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_store = 0; m_run = 0; m_pos = 0; m_div = 0;
    end else begin
      if (m_run == 0) begin
        if (master_en) begin m_run = 1; m_div = m_store; m_pos = 0; end
      end else if (m_pos == m_div) begin
        m_pos = 0;
        if (master_en) m_div = m_store;
        else m_run = 0;
      end else begin
        m_pos = m_pos + 1;
      end
      if (wr_en) m_store = wr_view ? (wr_data & 16'h07FF) : ((wr_data >> 8) & 16'h00FF);
    end
  end

  function automatic int exp_high();
    if (m_run == 0) return 0;
    if (m_div == 0) return 1;
    return (m_pos <= m_div / 2) ? 1 : 0;
  endfunction

  // compare every clock: mid high phase and mid low phase
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      checks++;
      if (int'(sclk) != exp_high()) begin
        errors++;
        $display("FAIL %s sclk (high phase) actual=%0d expected=%0d at cycle %0d",
                 (m_div == 0) ? "R6" : "R5 R7 R8", sclk, exp_high(), cycles);
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      int e;
      e = (m_run != 0 && m_div == 0) ? 0 : exp_high();
      checks++;
      if (int'(sclk) != e) begin
        errors++;
        $display("FAIL %s sclk (low phase) actual=%0d expected=%0d at cycle %0d",
                 (m_div == 0) ? "R6" : "R5 R7 R8", sclk, e, cycles);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic write_reg(input logic view, input logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_view = view; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 16'hA5C3;
  endtask

  task automatic check_rd(input logic view, input logic [15:0] exp, input string tag);
    @(negedge clk);
    rd_view = view;
    #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s rd_data view=%0d actual=%h expected=%h", tag, view, rd_data, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    check_rd(1'b0, 16'h0000, "R1");
    check_rd(1'b1, 16'h0000, "R1");
    idle(5);                          // R8: enable low keeps sclk low
    // R6 divide-by-1
    master_en = 1'b1;
    idle(10);
    // R2 extended write, even ratio 6
    write_reg(1'b1, 16'hF805);
    check_rd(1'b1, 16'h0005, "R2");
    check_rd(1'b0, 16'h0500, "R4");
    idle(20);
    // R7 legacy write mid-period, ratio 4
    idle(2);
    write_reg(1'b0, 16'h03FF);
    check_rd(1'b1, 16'h0003, "R3");
    idle(30);
    // R5 odd ratio 7
    write_reg(1'b1, 16'h0006);
    idle(40);
    // full-range ratio 2048
    write_reg(1'b1, 16'h07FF);
    check_rd(1'b1, 16'h07FF, "R2");
    check_rd(1'b0, 16'hFF00, "R4");
    idle(4200);
    // R3 legacy write after large extended value clears bits 10:8
    write_reg(1'b0, 16'h1234);
    check_rd(1'b1, 16'h0012, "R3");
    check_rd(1'b0, 16'h1200, "R4");
    idle(2100);
    // R9 data on the bus without strobe
    @(negedge clk);
    wr_view = 1'b1; wr_data = 16'h0444;
    idle(4);
    check_rd(1'b1, 16'h0012, "R9");
    // R8 disable mid-period, period completes then low
    write_reg(1'b1, 16'h0009);
    idle(25);
    master_en = 1'b0;
    idle(30);
    // restart at ratio 3 then back to divide-by-1
    master_en = 1'b1;
    write_reg(1'b0, 16'h0200);
    idle(20);
    write_reg(1'b1, 16'h0000);
    idle(10);
    master_en = 1'b0;
    idle(10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule